// File: doc/BRIEF.md
# Oversampled Data Phase Picker

The block recovers one data bit per bit period from a serial stream that a multiphase sampler has already captured at 32 evenly spaced instants across that period. Once per bit time a strobe arrives with the 32-sample word. The word is copied into a holding register, and only that held copy is examined. An edge exists at position `p` when samples `p-1` and `p` differ. Position 0 compares sample 0 with the last sample of the window held before it.

A 5-bit tracked edge position follows the data edges. It moves at most one tap per bit, so the sampling point never jumps. Windows with too many edges are treated as noise and ignored. Edges far from the current estimate are also ignored. The sampling tap sits half a bit away from the tracked edge, which is the middle of the eye. The recovered bit is the held sample at that tap.

A small controller has two named states. `ST_PRIME` waits for the first window after reset. `ST_RUN` evaluates the held window and captures the next one on every strobe. There are three transitions. Reset enters `ST_PRIME` from any state. A strobe in `ST_PRIME` captures the first window and moves to `ST_RUN` (the "prime" transition). A strobe in `ST_RUN` stays in `ST_RUN` (the "advance" transition): it evaluates the held window, updates the tracked position and the outputs, and captures the new window.

Top module: `phase_picker`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge `bit_valid` is 0, `bit_out` is 0, `tap_idx` is 16, the tracked edge position is 0, the held window is all zeros and the stored previous last sample is 0.
- R2: The first strobe after reset only captures a window. `bit_valid` stays 0 in the cycle after it.
- R3: Every later strobe makes `bit_valid` 1 for exactly the one cycle after the strobe edge. At all other times `bit_valid` is 0.
- R4: The edge at position `p` (1..31) is held sample `p` XOR held sample `p-1`. The edge at position 0 is held sample 0 XOR bit 31 of the window held before. That previous bit is 0 for the first window after reset.
- R5: If a held window has more than two edges, all of its edges are ignored and the tracked position does not change.
- R6: An edge is valid only if its circular distance from the tracked position is at most 8 taps. An edge exactly 8 taps away counts; an edge 9 taps away does not.
- R7: The tracked position moves by one tap, modulo 32, toward the nearest valid edge. It does not move when the nearest valid edge is at distance 0, or when two valid edges are equally near on opposite sides.
- R8: Each output uses the updated tracked position T. `tap_idx` = (T + 16) mod 32, and `bit_out` is held sample `tap_idx`.
- R9: A window with no valid edge leaves the tracked position unchanged and still produces a `bit_valid` pulse with a recovered bit.
- R10: Between consecutive outputs, `tap_idx` changes by 0, +1 or -1 modulo 32. It never changes while `bit_valid` is 0.
- R11: The outputs after a strobe depend only on the window captured at the previous strobe. `win_data` is ignored when `win_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_stb | input | 1 | One-cycle strobe, once per bit time |
| win_data | input | 32 | Samples of one bit period; bit i is the sample at tap i |
| bit_out | output | 1 | Recovered data bit |
| bit_valid | output | 1 | One-cycle pulse when `bit_out` and `tap_idx` are updated |
| tap_idx | output | 5 | Selected sampling tap |

## Verification
The hardest situation to reach from the ports is the tracked position crossing the wrap between taps 31 and 0 while it still rejects nearby noise. The tracker moves only one tap per bit and only toward edges it already accepts. Directed windows therefore walk it across the wrap first. They then place edges at exactly 8 and 9 taps, a tie between two equally near edges, a window with three edges including the boundary edge, and a boundary-only edge. After that, a random walk of the true data phase, with flipped samples and occasional garbage windows, drags the estimate around the whole circle. Each output is compared with a bench model of the edge rules.

// File: rtl/pp_pkg.sv
package pp_pkg;

    // Controller states
    typedef enum logic {
        ST_PRIME = 1'b0,   // waiting for the first window after reset
        ST_RUN   = 1'b1    // evaluating the held window on every strobe
    } ctrl_state_t;

    // Tracker decision for one bit
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_t;

endpackage

// File: rtl/pp_hold_reg.sv
module pp_hold_reg #(
    parameter int N_TAP = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [N_TAP-1:0] win_in,
    output logic [N_TAP-1:0] held,
    output logic             prev_last
);

    // On capture, the last sample of the outgoing window is kept so that
    // the boundary edge of the incoming window can be evaluated later.
    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= '0;
            prev_last <= 1'b0;
        end else if (cap_en) begin
            prev_last <= held[N_TAP-1];
            held      <= win_in;
        end
    end

endmodule

// File: rtl/pp_edge_find.sv
module pp_edge_find #(
    parameter int N_TAP     = 32,
    parameter int NOISE_MAX = 2
) (
    input  logic [N_TAP-1:0] held,
    input  logic             prev_last,
    output logic [N_TAP-1:0] edges,
    output logic             noisy
);

    localparam int CNT_W = $clog2(N_TAP + 1);

    logic [CNT_W-1:0] edge_cnt;

    // Transition between neighbouring samples; position 0 looks back
    // into the previous window.
    genvar p;
    generate
        for (p = 0; p < N_TAP; p++) begin : g_xor
            if (p == 0) begin : g_wrap
                assign edges[p] = held[p] ^ prev_last;
            end else begin : g_inner
                assign edges[p] = held[p] ^ held[p-1];
            end
        end
    endgenerate

    always_comb begin
        edge_cnt = '0;
        for (int i = 0; i < N_TAP; i++) begin
            edge_cnt = edge_cnt + CNT_W'(edges[i]);
        end
    end

    assign noisy = (edge_cnt > CNT_W'(NOISE_MAX));

endmodule

// File: rtl/pp_track.sv
module pp_track
    import pp_pkg::*;
#(
    parameter int N_TAP    = 32,
    parameter int DIST_MAX = 8
) (
    input  logic [N_TAP-1:0]         edges,
    input  logic                     noisy,
    input  logic [$clog2(N_TAP)-1:0] trk_q,
    output step_t                    step,
    output logic [$clog2(N_TAP)-1:0] trk_next
);

    localparam int IDX_W = $clog2(N_TAP);

    logic [IDX_W:0] best_mag;
    logic           hit_up;
    logic           hit_dn;
    logic           any_hit;

    // Nearest accepted edge, seen from the tracked position, on the circle.
    always_comb begin
        logic [IDX_W-1:0] off;
        logic [IDX_W-1:0] mag;
        best_mag = '1;
        hit_up   = 1'b0;
        hit_dn   = 1'b0;
        any_hit  = 1'b0;
        for (int p = 0; p < N_TAP; p++) begin
            off = IDX_W'(p) - trk_q;
            mag = off[IDX_W-1] ? (IDX_W'(0) - off) : off;
            if (edges[p] && !noisy && ({1'b0, mag} <= (IDX_W+1)'(DIST_MAX))) begin
                any_hit = 1'b1;
                if ({1'b0, mag} < best_mag) begin
                    best_mag = {1'b0, mag};
                    hit_up   = !off[IDX_W-1];
                    hit_dn   = off[IDX_W-1];
                end else if ({1'b0, mag} == best_mag) begin
                    hit_up   = hit_up | !off[IDX_W-1];
                    hit_dn   = hit_dn | off[IDX_W-1];
                end
            end
        end
    end

    always_comb begin
        if (!any_hit || (best_mag == '0) || (hit_up && hit_dn)) begin
            step = STEP_HOLD;
        end else if (hit_up) begin
            step = STEP_UP;
        end else begin
            step = STEP_DOWN;
        end
    end

    always_comb begin
        unique case (step)
            STEP_UP:   trk_next = trk_q + IDX_W'(1);
            STEP_DOWN: trk_next = trk_q - IDX_W'(1);
            default:   trk_next = trk_q;
        endcase
    end

endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
    import pp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic win_stb,
    output logic cap_en,
    output logic eval_en
);

    ctrl_state_t state_q;
    ctrl_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: prime (ST_PRIME -> ST_RUN), advance (ST_RUN -> ST_RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (win_stb) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        cap_en  = 1'b0;
        eval_en = 1'b0;
        unique case (state_q)
            ST_PRIME: begin
                cap_en = win_stb;
            end
            ST_RUN: begin
                cap_en  = win_stb;
                eval_en = win_stb;
            end
        endcase
    end

endmodule

// File: rtl/phase_picker.sv
module phase_picker
    import pp_pkg::*;
#(
    parameter int N_TAP     = 32,
    parameter int DIST_MAX  = 8,
    parameter int NOISE_MAX = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     win_stb,
    input  logic [N_TAP-1:0]         win_data,
    output logic                     bit_out,
    output logic                     bit_valid,
    output logic [$clog2(N_TAP)-1:0] tap_idx
);

    localparam int IDX_W = $clog2(N_TAP);
    localparam logic [IDX_W-1:0] HALF = IDX_W'(N_TAP / 2);

    logic [N_TAP-1:0] held;
    logic             prev_last;
    logic [N_TAP-1:0] edges;
    logic             noisy;
    step_t            step;
    logic [IDX_W-1:0] trk_q;
    logic [IDX_W-1:0] trk_next;
    logic [IDX_W-1:0] tap_next;
    logic             cap_en;
    logic             eval_en;

    pp_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .win_stb (win_stb),
        .cap_en  (cap_en),
        .eval_en (eval_en)
    );

    pp_hold_reg #(.N_TAP(N_TAP)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .win_in    (win_data),
        .held      (held),
        .prev_last (prev_last)
    );

    pp_edge_find #(.N_TAP(N_TAP), .NOISE_MAX(NOISE_MAX)) u_edge (
        .held      (held),
        .prev_last (prev_last),
        .edges     (edges),
        .noisy     (noisy)
    );

    pp_track #(.N_TAP(N_TAP), .DIST_MAX(DIST_MAX)) u_trk (
        .edges    (edges),
        .noisy    (noisy),
        .trk_q    (trk_q),
        .step     (step),
        .trk_next (trk_next)
    );

    // Mid-eye tap, half a bit away from the tracked edge
    assign tap_next = trk_next + HALF;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q     <= '0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
            tap_idx   <= HALF;
        end else begin
            bit_valid <= eval_en;
            if (eval_en) begin
                trk_q   <= trk_next;
                tap_idx <= tap_next;
                bit_out <= held[tap_next];
            end
        end
    end

endmodule

// File: rtl/pp_checker.sv
module pp_checker
    import pp_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             win_stb,
    input logic             bit_valid,
    input logic [IDX_W-1:0] tap_idx,
    input ctrl_state_t      st,
    input logic             noisy
);

    localparam logic [IDX_W-1:0] HALF = IDX_W'(1 << (IDX_W - 1));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!bit_valid && tap_idx == HALF));

    // R2
    prime_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (win_stb && st == ST_PRIME) |=> !bit_valid);

    // R3
    valid_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(win_stb));

    // R10
    tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |-> $stable(tap_idx));

    // R10
    tap_step_chk: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> ((IDX_W'(tap_idx - $past(tap_idx)) == IDX_W'(0)) ||
                       (IDX_W'(tap_idx - $past(tap_idx)) == IDX_W'(1)) ||
                       (IDX_W'(tap_idx - $past(tap_idx)) == '1)));

    // R5
    noise_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (win_stb && st == ST_RUN && noisy) |=> $stable(tap_idx));

endmodule

bind phase_picker pp_checker #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .win_stb   (win_stb),
    .bit_valid (bit_valid),
    .tap_idx   (tap_idx),
    .st        (u_ctrl.state_q),
    .noisy     (noisy)
);

// File: tb/sim_phase_picker.sv
`timescale 1ns/1ps
module sim_phase_picker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        win_stb = 1'b0;
    logic [31:0] win_data = '0;
    logic        bit_out;
    logic        bit_valid;
    logic [4:0]  tap_idx;

    phase_picker u0 (
        .clk       (clk),
        .rst       (rst),
        .win_stb   (win_stb),
        .win_data  (win_data),
        .bit_out   (bit_out),
        .bit_valid (bit_valid),
        .tap_idx   (tap_idx)
    );

    always #10 clk = ~clk;   // 50 MHz

    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // Reference model state
    logic [31:0] m_held   = '0;
    logic        m_prev   = 1'b0;
    int          m_trk    = 0;
    bit          m_primed = 1'b0;
    string       m_tag    = "";

    function automatic int circ(int p, int t);
        int d = (p - t + 64) % 32;
        if (d > 16) d -= 32;
        return d;
    endfunction

    function automatic int model_next(logic [31:0] w, logic pv, int t);
        int  cnt = 0;
        int  best = 99;
        bit  up = 0;
        bit  dn = 0;
        for (int p = 0; p < 32; p++) begin
            bit e = (p == 0) ? (w[0] ^ pv) : (w[p] ^ w[p-1]);
            if (e) cnt++;
        end
        if (cnt > 2) return t;
        for (int p = 0; p < 32; p++) begin
            bit e = (p == 0) ? (w[0] ^ pv) : (w[p] ^ w[p-1]);
            int d = circ(p, t);
            int a = (d < 0) ? -d : d;
            if (e && a <= 8) begin
                if (a < best) begin
                    best = a; up = (d >= 0); dn = (d < 0);
                end else if (a == best) begin
                    if (d >= 0) up = 1; else dn = 1;
                end
            end
        end
        if (best == 99 || best == 0 || (up && dn)) return t;
        return up ? (t + 1) % 32 : (t + 31) % 32;
    endfunction

    function automatic logic [31:0] mkwin(int ph, bit oldb, bit newb);
        logic [31:0] w;
        for (int i = 0; i < 32; i++) w[i] = (i < ph) ? oldb : newb;
        return w;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Strobe one window in; check the outputs produced for the held one.
    task automatic send(logic [31:0] w, string tag);
        int nt = 0, etap = 0;
        bit ebit = 0;
        if (m_primed) begin
            nt   = model_next(m_held, m_prev, m_trk);
            etap = (nt + 16) % 32;
            ebit = m_held[etap];
        end
        @(negedge clk);
        win_data = w;
        win_stb  = 1'b1;
        @(negedge clk);
        win_stb  = 1'b0;
        win_data = $urandom;   // R11: junk while no strobe
        if (m_primed) begin
            check(bit_valid == 1'b1, {m_tag, " R3"}, "bit_valid", int'(bit_valid), 1);
            check(tap_idx == 5'(etap), {m_tag, " R8"}, "tap_idx", int'(tap_idx), etap);
            check(bit_out == ebit, {m_tag, " R8 R11"}, "bit_out", int'(bit_out), int'(ebit));
            m_trk  = nt;
            m_prev = m_held[31];
        end else begin
            check(bit_valid == 1'b0, "R2", "bit_valid", int'(bit_valid), 0);
        end
        m_held   = w;
        m_primed = 1'b1;
        m_tag    = tag;
        @(negedge clk);
        check(bit_valid == 1'b0, "R3 gap", "bit_valid", int'(bit_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int  ph;
        bit  lastb;
        bit  newb;
        logic [31:0] w;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check(bit_valid == 1'b0, "R1", "bit_valid", int'(bit_valid), 0);
        check(tap_idx == 5'd16, "R1", "tap_idx", int'(tap_idx), 16);
        check(bit_out == 1'b0, "R1", "bit_out", int'(bit_out), 0);

        // Directed corners (tag describes how the window is evaluated)
        send(32'h0000_0000, "R9 no edge");
        send(32'h8000_0000, "R7 wrap down");
        send(32'h000F_FC00, "R5 R4 three edges");
        send(32'hFFF0_0000, "R6 far edge");
        send(32'hE000_0001, "R7 tie");
        send(32'h0000_0003, "R7 step up");
        send(32'hFFFF_FFFF, "R4 boundary only");
        send(32'h0000_00FF, "R6 distance 8");
        send(32'hFFFF_FC00, "R6 distance 9");

        // Random walk of the true data phase, with noise
        ph    = 3;
        lastb = 1'b1;
        for (int k = 0; k < 600; k++) begin
            int r = $urandom_range(0, 7);
            if (r == 0) ph = (ph + 1) % 32;
            else if (r == 1) ph = (ph + 31) % 32;
            newb = 1'($urandom_range(0, 1));
            w = mkwin(ph, lastb, newb);
            if ($urandom_range(0, 5) == 0) w[$urandom_range(0, 31)] ^= 1'b1;
            if ($urandom_range(0, 19) == 0) w = $urandom;
            lastb = w[31];
            send(w, "R7 R9 R11 random");
        end
        send(32'h0, "flush");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule